// File: doc/BRIEF.md
# Three-stage fetch, decode and execute pipeline

This block is the front end of a small in-order processor. Each instruction passes through three stages. Fetch puts an address on a read port whose data returns one cycle later. Decode identifies the returned word. Execute carries out the instruction. While one instruction executes, the next one is in decode and the one after that is being fetched. The program counter is the fetch address. An instruction that reads the PC in execute therefore sees its own address plus two instruction widths.

A mode input selects 32-bit (4-byte) or 16-bit (2-byte) instructions. There are four toy operations: do nothing, add an immediate to the PC, jump to an absolute address, and return from interrupt. Any redirect squashes the two younger instructions, so execution restarts only after two bubble cycles. An interrupt request is taken at an instruction boundary. The executing instruction completes, the fetch-stage PC is kept as the link, and fetch moves to a fixed vector. The return sets fetch to the link minus one instruction width. This resumes at the instruction that was in decode when the interrupt was taken.

An execute observation port shows, for every cycle, whether an instruction is executing, its address and the PC value it sees.

Top module: `pipe3_core`

## Requirements
- R1: While `rstN` is low, `imemAddr` is 0x4000 and `exValid` is low. The cycle after release fetches 0x4000, and that instruction shows on the execute port in the third cycle after release.
- R2: With no redirect, `imemAddr` grows by the instruction width every cycle. The width is 4 when `halfMode` is 0 and 2 when it is 1. `halfMode` changes only while `rstN` is low.
- R3: Once the pipeline is full, `exValid` is high every cycle, and `exAddr` steps by the width from one instruction to the next.
- R4: In 32-bit mode, `exPc` equals `exAddr` plus 8 whenever `exValid` is high.
- R5: In 16-bit mode, `exPc` equals `exAddr` plus 4 whenever `exValid` is high.
- R6: `imemData[15:12]` is the operation code and `imemData[11:0]` is an unsigned immediate. Code 0 does nothing. Codes 4 to 15 behave exactly like code 0.
- R7: Code 1 sends fetch to `exPc` plus the immediate. For example, the instruction at 0x4000 with immediate 4 in 32-bit mode sends fetch to 0x400C.
- R8: Code 2 sends fetch to the immediate times 16.
- R9: After any redirect, `exValid` is low for exactly two cycles, and then the target executes. The two squashed instructions have no effect, even when they are redirects.
- R10: When `irqReq` is high in a cycle whose executing instruction is valid, does not redirect and is not masked, that instruction completes. The link takes its `exPc`, fetch goes to 0x0100 and two bubbles follow. Further requests are ignored until a code 3 executes.
- R11: Code 3 sends fetch to the link minus the width and unmasks interrupts. Execution resumes at the instruction that was in decode when the interrupt was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| halfMode | input | 1 | 1 selects 2-byte instructions, 0 selects 4-byte instructions |
| irqReq | input | 1 | Level interrupt request |
| imemAddr | output | 16 | Fetch address (the architectural PC) |
| imemData | input | 16 | Instruction word for the address presented one cycle earlier |
| exValid | output | 1 | An instruction is executing this cycle |
| exAddr | output | 16 | Address of the executing instruction |
| exPc | output | 16 | PC value seen by the executing instruction |

## Verification
The first instruction after reset is due on the execute port in the third cycle after release. A redirect or interrupt entry made in execute in cycle c shows its target on `imemAddr` in cycle c+1. That cycle and c+2 show bubbles, and the target executes in c+3. The bench samples all outputs on the falling clock edge and drives `irqReq` in the same step. The interrupt decision in its reference model therefore uses exactly the request value that the design samples on the following rising edge. The model steps once per cycle in program order, with a bubble counter that it loads on every redirect.

// File: rtl/pipe3_pkg.sv
`timescale 1ns/1ps
package pipe3_pkg;

  localparam int OPC_W   = 4;
  localparam int IMM_W   = 12;
  localparam int FIELD_W = OPC_W + IMM_W;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_ADDPC = 2'd1,
    OP_JUMP  = 2'd2,
    OP_RETI  = 2'd3
  } opKind_e;

  typedef enum logic [2:0] {
    NEXT_SEQ = 3'd0,
    NEXT_REL = 3'd1,
    NEXT_ABS = 3'd2,
    NEXT_RET = 3'd3,
    NEXT_VEC = 3'd4
  } nextSel_e;

  // strobes from control to datapath
  typedef struct packed {
    nextSel_e nextSel;
    logic     flush;
    logic     saveLink;
  } pipeStrobe_t;

  function automatic opKind_e decodeOp(input logic [OPC_W-1:0] opc);
    case (opc)
      4'd1:    return OP_ADDPC;
      4'd2:    return OP_JUMP;
      4'd3:    return OP_RETI;
      default: return OP_NOP;
    endcase
  endfunction

endpackage

// File: rtl/pipe3_ctrl.sv
`timescale 1ns/1ps
module pipe3_ctrl
  import pipe3_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] decOpc,
  input  logic             irqReq,
  output pipeStrobe_t      strobe,
  output logic             exValid
);

  logic    decValid;
  logic    irqMask;
  opKind_e exOp;
  logic    redirect;
  logic    takeIrq;
  logic    exIsReturn;

  always_comb begin
    redirect   = exValid && (exOp != OP_NOP);
    exIsReturn = exValid && (exOp == OP_RETI);
    takeIrq    = exValid && !redirect && irqReq && !irqMask;

    strobe.flush    = redirect || takeIrq;
    strobe.saveLink = takeIrq;
    strobe.nextSel  = NEXT_SEQ;
    if (takeIrq) begin
      strobe.nextSel = NEXT_VEC;
    end else if (redirect) begin
      case (exOp)
        OP_ADDPC: strobe.nextSel = NEXT_REL;
        OP_JUMP:  strobe.nextSel = NEXT_ABS;
        OP_RETI:  strobe.nextSel = NEXT_RET;
        default:  strobe.nextSel = NEXT_SEQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid <= 1'b0;
      exValid  <= 1'b0;
      exOp     <= OP_NOP;
      irqMask  <= 1'b0;
    end else begin
      decValid <= !strobe.flush;
      exValid  <= decValid && !strobe.flush;
      exOp     <= (decValid && !strobe.flush) ? decodeOp(decOpc) : OP_NOP;
      if (takeIrq) begin
        irqMask <= 1'b1;
      end else if (exIsReturn) begin
        irqMask <= 1'b0;
      end
    end
  end

  // R9
  bubble_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> ##1 !exValid);

  // R10
  mask_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.saveLink |=> (irqMask && !exValid));

  // R10
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqMask && !exIsReturn) |=> irqMask);

endmodule

// File: rtl/pipe3_dpath.sv
`timescale 1ns/1ps
module pipe3_dpath
  import pipe3_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h4000,
  parameter logic [ADDR_W-1:0] IRQ_VECTOR = 16'h0100,
  parameter int                JUMP_SHIFT = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfMode,
  input  logic [IMM_W-1:0]  decImm,
  input  pipeStrobe_t       strobe,
  output logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] exAddr,
  output logic [ADDR_W-1:0] exPc
);

  localparam logic [ADDR_W-1:0] STEP_WIDE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] decAddr;
  logic [ADDR_W-1:0] exAddrQ;
  logic [ADDR_W-1:0] link;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] pcNext;
  logic [IMM_W-1:0]  exImm;

  always_comb step = halfMode ? STEP_HALF : STEP_WIDE;

  always_comb begin
    case (strobe.nextSel)
      NEXT_REL: pcNext = pc + ADDR_W'(exImm);
      NEXT_ABS: pcNext = ADDR_W'(exImm) << JUMP_SHIFT;
      NEXT_RET: pcNext = link - step;
      NEXT_VEC: pcNext = IRQ_VECTOR;
      default:  pcNext = pc + step;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= RESET_ADDR;
      decAddr <= RESET_ADDR;
      exAddrQ <= RESET_ADDR;
      exImm   <= '0;
      link    <= '0;
    end else begin
      pc      <= pcNext;
      decAddr <= pc;
      exAddrQ <= decAddr;
      exImm   <= strobe.flush ? '0 : decImm;
      if (strobe.saveLink) begin
        link <= pc;
      end
    end
  end

  assign fetchPc = pc;
  assign exAddr  = exAddrQ;
  assign exPc    = pc;

endmodule

// File: rtl/pipe3_core.sv
`timescale 1ns/1ps
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h4000,
  parameter logic [ADDR_W-1:0] IRQ_VECTOR = 16'h0100,
  parameter int                JUMP_SHIFT = 4
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               halfMode,
  input  logic               irqReq,
  output logic [ADDR_W-1:0]  imemAddr,
  input  logic [FIELD_W-1:0] imemData,
  output logic               exValid,
  output logic [ADDR_W-1:0]  exAddr,
  output logic [ADDR_W-1:0]  exPc
);

  pipeStrobe_t strobe;
  logic [ADDR_W-1:0] widthChk;

  pipe3_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .decOpc  (imemData[FIELD_W-1:IMM_W]),
    .irqReq  (irqReq),
    .strobe  (strobe),
    .exValid (exValid)
  );

  pipe3_dpath #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR),
    .IRQ_VECTOR (IRQ_VECTOR),
    .JUMP_SHIFT (JUMP_SHIFT)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .halfMode (halfMode),
    .decImm   (imemData[IMM_W-1:0]),
    .strobe   (strobe),
    .fetchPc  (imemAddr),
    .exAddr   (exAddr),
    .exPc     (exPc)
  );

  always_comb widthChk = halfMode ? ADDR_W'(2) : ADDR_W'(4);

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.flush |=> (imemAddr == $past(imemAddr) + widthChk));

  // R4 R5
  pc_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    exValid |-> (exPc == exAddr + (widthChk << 1)));

  // R10
  vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.saveLink |=> (imemAddr == IRQ_VECTOR));

endmodule

// File: tb/pipe3_core_tb_top.sv
`timescale 1ns/1ps
module pipe3_core_tb_top;

  localparam int RESET = 32'h4000;
  localparam int VEC   = 32'h0100;
  localparam int RUN   = 160;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        halfMode = 1'b0;
  logic        irqReq = 1'b0;
  logic [15:0] imemData = 16'h0;
  logic [15:0] imemAddr;
  logic        exValid;
  logic [15:0] exAddr;
  logic [15:0] exPc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] prog [int];

  int    expAddr, bub, link, width;
  bit    mask;
  string addrTag, bubTag;

  always #2 clk = ~clk;

  pipe3_core dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .halfMode (halfMode),
    .irqReq   (irqReq),
    .imemAddr (imemAddr),
    .imemData (imemData),
    .exValid  (exValid),
    .exAddr   (exAddr),
    .exPc     (exPc)
  );

  function automatic logic [15:0] wordAt(int a);
    if (prog.exists(a)) return prog[a];
    return 16'h0000;
  endfunction

  // instruction memory, one cycle of read latency
  initial forever begin
    @(posedge clk);
    imemData <= wordAt(int'(imemAddr));
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic stepCycle(bit wantIrq);
    logic [15:0] word;
    int opc, imm, nxt;
    irqReq = wantIrq;
    if (bub > 0) begin
      check(bubTag, "exValid bubble", {31'b0, exValid}, 32'd0);
      bub--;
    end else begin
      check((addrTag == "R3") ? "R3" : "R9", "exValid", {31'b0, exValid}, 32'd1);
      check(addrTag, "exAddr", {16'h0, exAddr}, expAddr);
      check((width == 4) ? "R4" : "R5", "exPc", {16'h0, exPc}, (expAddr + 2*width) & 16'hFFFF);
      word = wordAt(expAddr);
      opc  = int'(word[15:12]);
      imm  = int'(word[11:0]);
      case (opc)
        1: begin nxt = (expAddr + 2*width + imm) & 16'hFFFF; addrTag = "R7/R9"; bub = 2; bubTag = "R9"; end
        2: begin nxt = (imm << 4) & 16'hFFFF; addrTag = "R8"; bub = 2; bubTag = "R9"; end
        3: begin nxt = (link - width) & 16'hFFFF; mask = 0; addrTag = "R11"; bub = 2; bubTag = "R9"; end
        default: begin
          if (wantIrq && !mask) begin
            link = (expAddr + 2*width) & 16'hFFFF;
            mask = 1;
            nxt = VEC;
            addrTag = "R10"; bub = 2; bubTag = "R10";
          end else begin
            nxt = (expAddr + width) & 16'hFFFF;
            addrTag = (opc == 0) ? "R3" : "R6";
          end
        end
      endcase
      expAddr = nxt;
    end
  endtask

  task automatic runMode(bit half, int a0, int a1, int b0, int b1);
    rstN = 1'b0;
    irqReq = 1'b0;
    halfMode = half;
    repeat (3) @(negedge clk);
    check("R1", "imemAddr in reset", {16'h0, imemAddr}, RESET);
    check("R1", "exValid in reset", {31'b0, exValid}, 32'd0);
    width = half ? 2 : 4;
    expAddr = RESET; bub = 2; bubTag = "R1"; addrTag = "R1";
    mask = 0; link = 0;
    rstN = 1'b1;
    for (int cyc = 0; cyc < RUN; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (cyc == 0) check("R1", "first fetch", {16'h0, imemAddr}, RESET);
      if (cyc == 1) check("R2", "fetch step", {16'h0, imemAddr}, RESET + width);
      stepCycle(((cyc >= a0) && (cyc <= a1)) || ((cyc >= b0) && (cyc <= b1)));
    end
    irqReq = 1'b0;
    rstN = 1'b0;
  endtask

  initial begin
    // 32-bit program
    prog[32'h4000] = 16'h1004;  // add 4 to PC: target 0x400C
    prog[32'h4004] = 16'h2300;  // squashed jump
    prog[32'h4008] = 16'h3000;  // squashed return
    prog[32'h4010] = 16'hF000;  // unknown code
    prog[32'h4018] = 16'h2500;  // jump 0x5000
    prog[32'h5040] = 16'h2400;  // jump 0x4000
    prog[32'h0108] = 16'h3000;  // return
    runMode(1'b0, 30, 31, 70, 110);

    prog.delete();
    // 16-bit program
    prog[32'h4000] = 16'h1006;  // target 0x4004 + 6 = 0x400A
    prog[32'h4002] = 16'h2300;
    prog[32'h4004] = 16'h3000;
    prog[32'h400C] = 16'hA123;  // unknown code
    prog[32'h400E] = 16'h2500;
    prog[32'h5020] = 16'h2400;
    prog[32'h0102] = 16'h3000;
    runMode(1'b1, 20, 21, 50, 90);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule